// File: doc/BRIEF.md
# MAC Interrupt Event Collector

This block gathers single-cycle event pulses produced elsewhere in a network MAC (receive completion, descriptor shortage, receive FIFO overflow, early receive and transmit notices, transmit completion, statistics counter wrap and PHY link changes). It holds each one in a sticky status word until host software collects it. A second word, written by the host, chooses which of the held events may raise the single level-sensitive interrupt line.

Software talks to the block through a small word-wide register port with a read strobe, a write strobe and a word address. Reading the status word hands back every held event and empties the word in the same access. A typical handler saves the enable word, writes zero to it to silence the line, and collects the status. It then writes the saved enable value back. Events that arrive while the line is silenced are still held and raise the line again once the enable value is restored.

Top module: `mac_irq_collector`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the status word, the enable word and `reg_rdata` become zero, and `irq` is low from the following cycle on.
- R2: An event pulse on a live input bit (bit 0 receive done, bit 1 no receive descriptor, bit 2 receive FIFO full, bit 3 receive early, bit 4 transmit done, bit 7 transmit early, bit 8 counter wrap, bit 9 link change) sets the matching status bit at the next edge. The bit stays set until a status read clears it.
- R3: A read of word address 0 puts the status word as it stood before that edge on `reg_rdata` one cycle later, and clears every status bit that no new event sets at that edge.
- R4: An event that coincides with a clearing status read is left set in the status word after the read.
- R5: Status and enable bits 5, 6 and 10 to 15 always read as zero, whatever events or write data are applied to them.
- R6: A write to word address 1 stores the write data (live bits only) as the enable word. A read of address 1 returns that word on `reg_rdata` one cycle later.
- R7: `irq` is high exactly when some bit is set in both the status word and the enable word.
- R8: Writing 0x0000 to the enable word drops `irq` from the next cycle. Status bits keep latching while masked, and restoring the enable word raises `irq` again if any enabled event was held.
- R9: Writes to address 0 or to any unmapped address change nothing. Reads of unmapped addresses return zero. `reg_rdata` holds its last value on cycles without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_pulse | input | 16 | Event pulses, one bit per source, one cycle each |
| reg_rd | input | 1 | Host read strobe |
| reg_wr | input | 1 | Host write strobe |
| reg_addr | input | 2 | Word address: 0 status, 1 enable |
| reg_wdata | input | 16 | Host write data |
| reg_rdata | output | 16 | Registered read data |
| irq | output | 1 | Level interrupt request |

## Verification
A corrupted status bit shows up within one cycle as a wrong `irq` level whenever that bit is enabled. Otherwise it appears in `reg_rdata` on the cycle after the next status read. A lost event at a clearing read is found by the read that follows. A wrong enable word is seen on `irq` as soon as any matching event is held, and on the next enable read-back. The bench compares `irq` and `reg_rdata` against a behavioural model on every clock, so any of these faults is flagged within a cycle or two of becoming visible.

// File: rtl/mac_irq_pkg.sv
// Package: shared constants for the MAC interrupt event collector.
// Assumes a 16-bit register word and two mapped word addresses.
package mac_irq_pkg;
    localparam int WORD_W = 16;
    localparam int ADDR_W = 2;

    // Source bit positions (hardware event inputs and status bits share them)
    localparam int SRC_RX_DONE   = 0;
    localparam int SRC_RX_NODESC = 1;
    localparam int SRC_RX_FULL   = 2;
    localparam int SRC_RX_EARLY  = 3;
    localparam int SRC_TX_DONE   = 4;
    localparam int SRC_TX_EARLY  = 7;
    localparam int SRC_CNT_WRAP  = 8;
    localparam int SRC_LINK_CHG  = 9;

    localparam logic [WORD_W-1:0] LIVE_MASK =
        WORD_W'((1 << SRC_RX_DONE)  | (1 << SRC_RX_NODESC) |
                (1 << SRC_RX_FULL)  | (1 << SRC_RX_EARLY)  |
                (1 << SRC_TX_DONE)  | (1 << SRC_TX_EARLY)  |
                (1 << SRC_CNT_WRAP) | (1 << SRC_LINK_CHG));

    typedef enum logic [ADDR_W-1:0] {
        WADDR_STATUS = 2'd0,
        WADDR_ENABLE = 2'd1
    } word_addr_e;
endpackage

// File: rtl/mac_irq_status.sv
// Sticky status word: each live bit sets on an event pulse and clears on a
// host status read. An event at the clearing edge wins, so none is lost.
// Assumes clr_i is a single-cycle strobe; dead bit positions are never stored.
module mac_irq_status #(
    parameter int                 WORD_W    = 16,
    parameter logic [WORD_W-1:0]  LIVE_MASK = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] evt_i,
    input  logic              clr_i,
    output logic [WORD_W-1:0] stat_o
);
    logic [WORD_W-1:0] stat_q;
    logic [WORD_W-1:0] evt_live;
    logic [WORD_W-1:0] keep;

    // Purpose: restrict incoming pulses to the live source positions
    always_comb evt_live = evt_i & LIVE_MASK;

    // Purpose: choose whether existing bits survive this edge
    always_comb keep = clr_i ? '0 : stat_q;

    // Purpose: update the sticky status word
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= keep | evt_live;
    end

    assign stat_o = stat_q;

    AST_EVT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_live) |=> ((stat_q & $past(evt_live)) == $past(evt_live))); // R2
    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> ((stat_q & ~$past(evt_live)) == '0)); // R3
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R2
endmodule

// File: rtl/mac_irq_enable.sv
// Host-written enable word; only live bit positions are stored.
// Assumes wr_i is a single-cycle strobe already decoded to the enable address.
module mac_irq_enable #(
    parameter int                 WORD_W    = 16,
    parameter logic [WORD_W-1:0]  LIVE_MASK = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [WORD_W-1:0] en_o
);
    logic [WORD_W-1:0] en_q;

    // Purpose: capture the enable word on a host write
    always_ff @(posedge clk) begin
        if (!rst_n)    en_q <= '0;
        else if (wr_i) en_q <= wdata_i & LIVE_MASK;
    end

    assign en_o = en_q;

    AST_EN_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (en_q == ($past(wdata_i) & LIVE_MASK))); // R6
    AST_EN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(en_q)); // R6
endmodule

// File: rtl/mac_irq_line.sv
// Interrupt line: high while any status bit is also enabled.
// REG_OUT selects a direct (0) or a flopped (1) output; the default is direct.
module mac_irq_line #(
    parameter int WORD_W  = 16,
    parameter bit REG_OUT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] stat_i,
    input  logic [WORD_W-1:0] en_i,
    output logic              irq_o
);
    logic pend;

    // Purpose: detect any enabled, pending source
    always_comb pend = |(stat_i & en_i);

    if (REG_OUT) begin : g_flop
        logic irq_q;
        // Purpose: retime the request to a flop output
        always_ff @(posedge clk) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= pend;
        end
        assign irq_o = irq_q;
    end else begin : g_direct
        assign irq_o = pend;
    end
endmodule

// File: rtl/mac_irq_collector.sv
// Top: decodes the host register port, holds the read data register and
// joins status, enable and interrupt line. Assumes strobes last one cycle
// per access; status reads clear, writes to the status address are dropped.
module mac_irq_collector
    import mac_irq_pkg::*;
#(
    parameter int                 DATA_W   = WORD_W,
    parameter int                 AW       = ADDR_W,
    parameter logic [DATA_W-1:0]  SRC_MASK = LIVE_MASK
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] evt_pulse,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [AW-1:0]     reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    localparam logic [AW-1:0] A_STAT = AW'(WADDR_STATUS);
    localparam logic [AW-1:0] A_EN   = AW'(WADDR_ENABLE);

    logic              hit_stat;
    logic              hit_en;
    logic              stat_clr;
    logic              en_wr;
    logic [DATA_W-1:0] stat_w;
    logic [DATA_W-1:0] en_w;
    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] rdata_q;

    // Purpose: decode the word address
    always_comb begin
        hit_stat = (reg_addr == A_STAT);
        hit_en   = (reg_addr == A_EN);
    end

    // Purpose: form the clear and write strobes
    always_comb begin
        stat_clr = reg_rd & hit_stat;
        en_wr    = reg_wr & hit_en;
    end

    mac_irq_status #(.WORD_W(DATA_W), .LIVE_MASK(SRC_MASK)) i_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (evt_pulse),
        .clr_i  (stat_clr),
        .stat_o (stat_w)
    );

    mac_irq_enable #(.WORD_W(DATA_W), .LIVE_MASK(SRC_MASK)) i_enable (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (en_wr),
        .wdata_i (reg_wdata),
        .en_o    (en_w)
    );

    mac_irq_line #(.WORD_W(DATA_W), .REG_OUT(1'b0)) i_line (
        .clk    (clk),
        .rst_n  (rst_n),
        .stat_i (stat_w),
        .en_i   (en_w),
        .irq_o  (irq)
    );

    // Purpose: select the word returned by a read
    always_comb begin
        if (hit_stat)    rd_mux = stat_w;
        else if (hit_en) rd_mux = en_w;
        else             rd_mux = '0;
    end

    // Purpose: register read data; hold it between reads
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (reg_rd) rdata_q <= rd_mux;
    end

    assign reg_rdata = rdata_q;

    AST_RDATA_DEAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((reg_rdata & ~SRC_MASK) == '0)); // R5
    AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(|(evt_pulse & en_w)) || $past(en_wr)); // R7
    AST_MASK_ALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (en_wr && reg_wdata == '0) |=> !irq); // R8
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(reg_rdata)); // R9
    AST_STAT_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !hit_en) |=> $stable(en_w)); // R9
endmodule

// File: tb/test_mac_irq_collector.sv
`timescale 1ns/1ps
module test_mac_irq_collector;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] evt_pulse = '0;
    logic        reg_rd = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    // Reference state, behavioural
    int unsigned m_stat = 0;
    int unsigned m_en   = 0;
    int unsigned m_rd   = 0;
    localparam int unsigned LIVE = 32'h0000_039F; // bits 0-4,7,8,9 (R5)

    always #4 clk = ~clk;

    mac_irq_collector i_mac_irq_collector (
        .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .reg_rd(reg_rd),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic compare(input string tag);
        bit exp_irq;
        exp_irq = (m_stat & m_en) != 0;
        vectors++;
        if (irq !== exp_irq || reg_rdata !== 16'(m_rd)) begin
            misses++;
            $display("FAIL %s: irq=%0b rdata=%h expected irq=%0b rdata=%h",
                     tag, irq, reg_rdata, exp_irq, 16'(m_rd));
        end
    endtask

    // Compare now (negedge), drive one cycle of inputs, advance the model.
    task automatic cyc(input bit rd, input bit wr, input int unsigned a,
                       input int unsigned wd, input int unsigned ev,
                       input string tag);
        int unsigned nstat;
        compare(tag);
        reg_rd = rd; reg_wr = wr; reg_addr = 2'(a);
        reg_wdata = 16'(wd); evt_pulse = 16'(ev);
        if (!rst_n) begin
            m_stat = 0; m_en = 0; m_rd = 0;
        end else begin
            if (rd) m_rd = (a == 0) ? m_stat : (a == 1) ? m_en : 0;
            nstat = (rd && a == 0) ? 0 : m_stat;
            nstat = nstat | (ev & 16'hFFFF & LIVE);
            if (wr && a == 1) m_en = wd & LIVE;
            m_stat = nstat;
        end
        @(negedge clk);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, tag);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            misses++;
            $display("FAIL watchdog: run did not finish, expected completion");
            summary();
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        // R1: reset state
        idle(3, "R1");
        cyc(1, 0, 0, 0, 16'hFFFF, "R1"); // read during reset: stays zero
        rst_n = 1'b1;
        idle(2, "R1");
        // R2: single events latch and stick
        cyc(0, 0, 0, 0, 16'h0001, "R2");
        idle(3, "R2");
        cyc(0, 0, 0, 0, 16'h0200, "R2");
        // R3: clearing read, then empty re-read
        cyc(1, 0, 0, 0, 0, "R3");
        cyc(1, 0, 0, 0, 0, "R3");
        idle(1, "R3");
        // R6/R7: enable write, readback, interrupt
        cyc(0, 1, 1, 16'h0011, 0, "R6");
        cyc(1, 0, 1, 0, 0, "R6");
        cyc(0, 0, 0, 0, 16'h0010, "R7");
        idle(2, "R7");
        cyc(0, 0, 0, 0, 16'h0002, "R7"); // not enabled
        // R4: event at the clearing read survives
        cyc(1, 0, 0, 0, 16'h0001, "R4");
        cyc(1, 0, 0, 0, 0, "R4");
        idle(1, "R4");
        // R5: dead bits
        cyc(0, 0, 0, 0, 16'hFC60, "R5");
        cyc(1, 0, 0, 0, 0, "R5");
        cyc(0, 1, 1, 16'hFFFF, 16'hFFFF, "R5");
        cyc(1, 0, 1, 0, 0, "R5");
        cyc(1, 0, 0, 0, 0, "R5");
        idle(1, "R5");
        // R8: save, mask all, collect, latch while masked, restore
        cyc(0, 0, 0, 0, 16'h0100, "R8");
        cyc(1, 0, 1, 0, 0, "R8");
        cyc(0, 1, 1, 0, 0, "R8");
        cyc(1, 0, 0, 0, 16'h0008, "R8");
        cyc(0, 0, 0, 0, 16'h0080, "R8");
        idle(2, "R8");
        cyc(0, 1, 1, 16'h039F, 0, "R8");
        idle(2, "R8");
        // R9: status-address write and unmapped accesses do nothing
        cyc(0, 1, 0, 16'h0000, 0, "R9");
        cyc(0, 1, 2, 16'h0000, 0, "R9");
        cyc(0, 1, 3, 16'h0000, 0, "R9");
        cyc(1, 0, 2, 0, 0, "R9");
        idle(2, "R9");
        cyc(1, 0, 3, 0, 0, "R9");
        cyc(1, 0, 1, 0, 0, "R9");
        cyc(1, 0, 0, 0, 0, "R9");
        idle(1, "R9");
        // Mixed traffic against the model (R2, R3, R4, R7 together)
        for (int i = 0; i < 600; i++) begin
            int unsigned r;
            r = $urandom;
            cyc((r % 4) == 0, (r % 7) == 0, (r >> 4) % 4, $urandom,
                ((r >> 8) % 3 == 0) ? $urandom : 0, "R7");
        end
        // R1: reset mid-run with pending state
        cyc(0, 1, 1, 16'hFFFF, 16'hFFFF, "R1");
        rst_n = 1'b0;
        idle(2, "R1");
        rst_n = 1'b1;
        idle(2, "R1");
        done = 1'b1;
        summary();
    end
endmodule